// File: doc/BRIEF.md
# Dual-Lane Conditional Register Move Unit

This block holds two register files, a primary set (R) and a secondary set (S). Each set belongs to its own processing lane. The block carries out conditional register-to-register copies and swaps between and within the two sets. Each operation arrives as one strobed command. The command gives a move form, a destination index x, a source index y and one condition bit per lane. The condition bits are already evaluated; computing them is not part of this block.

A mode input selects how a command is applied. In single-lane mode a command performs only its named (explicit) transfer, gated by the primary lane's condition. In paired-lane mode every command also performs a mirrored (implicit) transfer on the other lane. Each of the two transfers is gated by its own lane's condition.

A separate load port writes one entry in either file. It stands in for the result path of the surrounding datapath. Two peek ports read the files asynchronously.

Top module: `dual_lane_xfer_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, every entry of both files reads as zero. A later reset assertion clears the files again.
- R2: In single-lane mode (`simd_mode`=0), a command with `cond_pri`=0 changes no entry, whatever `cond_sec` is. `cond_sec` never affects a single-lane command.
- R3: The move-form encoding is 0: R[x]=R[y], 1: R[x]=S[y], 2: S[x]=R[y], 3: S[x]=S[y]. In single-lane mode with `cond_pri`=1, a move writes only its named destination, and the other set is untouched.
- R4: Encoding 4 is the swap. In single-lane mode with `cond_pri`=1 it loads R[x] from S[y] and S[y] from R[x]. Both halves are gated together by `cond_pri`.
- R5: In paired-lane mode each move adds a mirrored transfer with the same x and y and with both sets exchanged. Form 0 adds S[x]=S[y], form 1 adds S[x]=R[y], form 2 adds R[x]=S[y], and form 3 adds R[x]=R[y].
- R6: In paired-lane mode the named transfer happens only when `cond_pri`=1, and the mirrored transfer only when `cond_sec`=1. The two are independent.
- R7: In paired-lane mode the swap writes R[x] (from S[y]) only when `cond_pri`=1, and S[y] (from R[x]) only when `cond_sec`=1.
- R8: All sources are read before any write lands. A swap exchanges the old values, including when x equals y. A paired-lane form 1 or form 2 with x equal to y exchanges R[x] and S[x].
- R9: With `op_valid`=0, or with move-form codes 5, 6 and 7, no move takes place. A load (`ld_valid`=1, `ld_to_s` selecting S when 1) writes `ld_data` to entry `ld_idx` only in a cycle where `op_valid`=0.
- R10: Writes take effect on the rising clock edge that samples the command. Peek ports show the new value after that edge and the old value before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Command strobe |
| simd_mode | input | 1 | 0 single-lane, 1 paired-lane |
| op_code | input | 3 | Move form, 0 to 4 valid |
| dst_idx | input | 4 | Destination index x |
| src_idx | input | 4 | Source index y |
| cond_pri | input | 1 | Primary lane condition result |
| cond_sec | input | 1 | Secondary lane condition result |
| ld_valid | input | 1 | Load strobe |
| ld_to_s | input | 1 | Load target, 0 R set, 1 S set |
| ld_idx | input | 4 | Load entry index |
| ld_data | input | 40 | Load value |
| peek_r_idx | input | 4 | R set peek index |
| peek_r_data | output | 40 | R set peek value |
| peek_s_idx | input | 4 | S set peek index |
| peek_s_data | output | 40 | S set peek value |

## Verification
The bench builds the block with its default parameters: 16 entries of 40 bits per set. At that size all 32 entries can be compared after every command, so a stray write to any entry is caught, not only a missing write to the destination. The 40-bit width lets every entry hold its own value, including in the upper bits, so a wrong source index or a wrong set always shows up as a data mismatch. Index patterns cover x equal to y, index 0 and index 15, so both the read-before-write ordering and the address ends are checked.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
  typedef enum logic [2:0] {
    MV_R_FROM_R = 3'd0,
    MV_R_FROM_S = 3'd1,
    MV_S_FROM_R = 3'd2,
    MV_S_FROM_S = 3'd3,
    MV_EXCHANGE = 3'd4
  } mv_form_e;

  typedef struct packed {
    logic r_we;
    logic s_we;
    logic r_src_s;
    logic s_src_r;
  } wr_ctl_t;
endpackage

// File: rtl/dlx_rst_sync.sv
module dlx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dlx_decode.sv
module dlx_decode
  import dlx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             op_valid,
  input  logic             simd_mode,
  input  logic [2:0]       op_code,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  input  logic             cond_pri,
  input  logic             cond_sec,
  output wr_ctl_t          ctl,
  output logic [IDX_W-1:0] r_waddr,
  output logic [IDX_W-1:0] s_waddr,
  output logic [IDX_W-1:0] r_raddr,
  output logic [IDX_W-1:0] s_raddr
);
  logic is_swap;
  logic mirror_en;

  assign is_swap   = (op_code == MV_EXCHANGE);
  assign mirror_en = simd_mode & cond_sec;

  // The swap reads R at x; every other form reads both sets at y
  assign r_raddr = is_swap ? dst_idx : src_idx;
  assign s_raddr = src_idx;
  assign r_waddr = dst_idx;
  assign s_waddr = is_swap ? src_idx : dst_idx;

  always_comb begin
    ctl = '0;
    if (op_valid) begin
      unique case (op_code)
        MV_R_FROM_R: begin
          ctl.r_we = cond_pri;  ctl.r_src_s = 1'b0;
          ctl.s_we = mirror_en; ctl.s_src_r = 1'b0;
        end
        MV_R_FROM_S: begin
          ctl.r_we = cond_pri;  ctl.r_src_s = 1'b1;
          ctl.s_we = mirror_en; ctl.s_src_r = 1'b1;
        end
        MV_S_FROM_R: begin
          ctl.s_we = cond_pri;  ctl.s_src_r = 1'b1;
          ctl.r_we = mirror_en; ctl.r_src_s = 1'b1;
        end
        MV_S_FROM_S: begin
          ctl.s_we = cond_pri;  ctl.s_src_r = 1'b0;
          ctl.r_we = mirror_en; ctl.r_src_s = 1'b0;
        end
        MV_EXCHANGE: begin
          ctl.r_we    = cond_pri;
          ctl.r_src_s = 1'b1;
          ctl.s_we    = simd_mode ? cond_sec : cond_pri;
          ctl.s_src_r = 1'b1;
        end
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/dlx_regfile.sv
module dlx_regfile #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic [IDX_W-1:0] peek_addr,
  output logic [WIDTH-1:0] peek_data
);
  logic [WIDTH-1:0] entry_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic             en;
    logic [WIDTH-1:0] entry_d;

    always_comb begin
      en      = we && (waddr == IDX_W'(i));
      entry_d = en ? wdata : entry_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  entry_q[i] <= '0;
      else if (en) entry_q[i] <= entry_d;
    end
  end

  assign rdata     = entry_q[raddr];
  assign peek_data = entry_q[peek_addr];
endmodule

// File: rtl/dual_lane_xfer_unit.sv
module dual_lane_xfer_unit
  import dlx_pkg::*;
#(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             simd_mode,
  input  logic [2:0]       op_code,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  input  logic             cond_pri,
  input  logic             cond_sec,
  input  logic             ld_valid,
  input  logic             ld_to_s,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [IDX_W-1:0] peek_r_idx,
  output logic [WIDTH-1:0] peek_r_data,
  input  logic [IDX_W-1:0] peek_s_idx,
  output logic [WIDTH-1:0] peek_s_data
);
  logic             rst_n_sync;
  wr_ctl_t          mv_ctl;
  logic [IDX_W-1:0] mv_r_waddr, mv_s_waddr, r_raddr, s_raddr;
  logic [WIDTH-1:0] r_rdata, s_rdata;
  logic             ld_r_en, ld_s_en;
  logic             r_wr_en, s_wr_en;
  logic [IDX_W-1:0] r_waddr, s_waddr;
  logic [WIDTH-1:0] r_wdata, s_wdata;

  dlx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dlx_decode #(.IDX_W(IDX_W)) u_dec (
    .op_valid  (op_valid),
    .simd_mode (simd_mode),
    .op_code   (op_code),
    .dst_idx   (dst_idx),
    .src_idx   (src_idx),
    .cond_pri  (cond_pri),
    .cond_sec  (cond_sec),
    .ctl       (mv_ctl),
    .r_waddr   (mv_r_waddr),
    .s_waddr   (mv_s_waddr),
    .r_raddr   (r_raddr),
    .s_raddr   (s_raddr)
  );

  // Load path yields to any command in the same cycle
  always_comb begin
    ld_r_en = ld_valid & ~op_valid & ~ld_to_s;
    ld_s_en = ld_valid & ~op_valid &  ld_to_s;
    r_wr_en = mv_ctl.r_we | ld_r_en;
    s_wr_en = mv_ctl.s_we | ld_s_en;
    r_waddr = mv_ctl.r_we ? mv_r_waddr : ld_idx;
    s_waddr = mv_ctl.s_we ? mv_s_waddr : ld_idx;
    if (mv_ctl.r_we) r_wdata = mv_ctl.r_src_s ? s_rdata : r_rdata;
    else             r_wdata = ld_data;
    if (mv_ctl.s_we) s_wdata = mv_ctl.s_src_r ? r_rdata : s_rdata;
    else             s_wdata = ld_data;
  end

  dlx_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rfile_r (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .we        (r_wr_en),
    .waddr     (r_waddr),
    .wdata     (r_wdata),
    .raddr     (r_raddr),
    .rdata     (r_rdata),
    .peek_addr (peek_r_idx),
    .peek_data (peek_r_data)
  );

  dlx_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rfile_s (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .we        (s_wr_en),
    .waddr     (s_waddr),
    .wdata     (s_wdata),
    .raddr     (s_raddr),
    .rdata     (s_rdata),
    .peek_addr (peek_s_idx),
    .peek_data (peek_s_data)
  );
endmodule

// File: rtl/dlx_checker.sv
module dlx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       simd_mode,
  input logic [2:0] op_code,
  input logic       cond_pri,
  input logic       cond_sec,
  input logic       ld_valid,
  input logic       r_wr_en,
  input logic       s_wr_en
);
  AST_SISD_FALSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !simd_mode && !cond_pri) |-> (!r_wr_en && !s_wr_en)); // R2

  AST_SISD_R_DEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !simd_mode && op_code <= 3'd1) |-> !s_wr_en); // R3

  AST_SISD_S_DEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !simd_mode && (op_code == 3'd2 || op_code == 3'd3)) |-> !r_wr_en); // R3

  AST_SISD_SWAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !simd_mode && op_code == 3'd4 && cond_pri) |-> (r_wr_en && s_wr_en)); // R4

  AST_SIMD_MIRROR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && simd_mode && op_code <= 3'd3 && cond_pri && cond_sec) |-> (r_wr_en && s_wr_en)); // R5

  AST_SIMD_NO_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && simd_mode && !cond_pri && !cond_sec) |-> (!r_wr_en && !s_wr_en)); // R6

  AST_SIMD_SWAP_SEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && simd_mode && op_code == 3'd4 && !cond_pri && cond_sec) |-> (!r_wr_en && s_wr_en)); // R7

  AST_BAD_FORM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 3'd5) |-> (!r_wr_en && !s_wr_en)); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !ld_valid) |-> (!r_wr_en && !s_wr_en)); // R9
endmodule

bind dual_lane_xfer_unit dlx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .simd_mode (simd_mode),
  .op_code   (op_code),
  .cond_pri  (cond_pri),
  .cond_sec  (cond_sec),
  .ld_valid  (ld_valid),
  .r_wr_en   (r_wr_en),
  .s_wr_en   (s_wr_en)
);

// File: tb/dual_lane_xfer_unit_tb.sv
`timescale 1ns/1ps
module dual_lane_xfer_unit_tb;
  localparam int W = 40;
  localparam int D = 16;
  localparam int IW = 4;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst_n, op_valid, simd_mode, cond_pri, cond_sec;
  logic [2:0]    op_code;
  logic [IW-1:0] dst_idx, src_idx, ld_idx, peek_r_idx, peek_s_idx;
  logic          ld_valid, ld_to_s;
  logic [W-1:0]  ld_data, peek_r_data, peek_s_data;

  logic [W-1:0]  mr [D];
  logic [W-1:0]  ms [D];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_lane_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .simd_mode(simd_mode),
    .op_code(op_code), .dst_idx(dst_idx), .src_idx(src_idx),
    .cond_pri(cond_pri), .cond_sec(cond_sec), .ld_valid(ld_valid),
    .ld_to_s(ld_to_s), .ld_idx(ld_idx), .ld_data(ld_data),
    .peek_r_idx(peek_r_idx), .peek_r_data(peek_r_data),
    .peek_s_idx(peek_s_idx), .peek_s_data(peek_s_data)
  );

  // {simd, form, x, y, cond_pri, cond_sec}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 3'd0, 4'd3,  4'd5,  1'b1, 1'b0},  // R3 form 0
    {1'b0, 3'd1, 4'd7,  4'd2,  1'b1, 1'b1},  // R3 form 1, R2 sec ignored
    {1'b0, 3'd2, 4'd4,  4'd9,  1'b1, 1'b0},  // R3 form 2
    {1'b0, 3'd3, 4'd1,  4'd12, 1'b1, 1'b1},  // R3 form 3
    {1'b0, 3'd0, 4'd6,  4'd8,  1'b0, 1'b1},  // R2 pri false
    {1'b0, 3'd4, 4'd10, 4'd11, 1'b1, 1'b0},  // R4 swap
    {1'b0, 3'd4, 4'd2,  4'd2,  1'b0, 1'b1},  // R2 swap blocked
    {1'b1, 3'd0, 4'd0,  4'd15, 1'b1, 1'b1},  // R5 form 0 mirror
    {1'b1, 3'd1, 4'd13, 4'd6,  1'b1, 1'b1},  // R5 form 1 mirror
    {1'b1, 3'd2, 4'd8,  4'd1,  1'b1, 1'b1},  // R5 form 2 mirror
    {1'b1, 3'd3, 4'd14, 4'd3,  1'b1, 1'b1},  // R5 form 3 mirror
    {1'b1, 3'd1, 4'd5,  4'd10, 1'b1, 1'b0},  // R6 explicit only
    {1'b1, 3'd2, 4'd9,  4'd4,  1'b0, 1'b1},  // R6 implicit only
    {1'b1, 3'd4, 4'd11, 4'd7,  1'b1, 1'b0},  // R7 R half only
    {1'b1, 3'd4, 4'd12, 4'd0,  1'b0, 1'b1},  // R7 S half only
    {1'b1, 3'd4, 4'd3,  4'd3,  1'b1, 1'b1},  // R7 R8 swap x==y
    {1'b1, 3'd1, 4'd15, 4'd15, 1'b1, 1'b1},  // R8 cross exchange
    {1'b0, 3'd4, 4'd6,  4'd6,  1'b1, 1'b0},  // R4 R8 swap x==y
    {1'b1, 3'd0, 4'd2,  4'd2,  1'b1, 1'b1}   // R8 self copy
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < D; i++) begin
      peek_r_idx = IW'(i);
      peek_s_idx = IW'(i);
      #0.5;
      chk($sformatf("%s R[%0d]", tag, i), peek_r_data, mr[i]);
      chk($sformatf("%s S[%0d]", tag, i), peek_s_data, ms[i]);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; simd_mode = 0; op_code = 0; dst_idx = 0; src_idx = 0;
    cond_pri = 0; cond_sec = 0; ld_valid = 0; ld_to_s = 0; ld_idx = 0; ld_data = '0;
  endtask

  task automatic load(input bit to_s, input int idx, input logic [W-1:0] val);
    @(negedge clk);
    ld_valid = 1; ld_to_s = to_s; ld_idx = IW'(idx); ld_data = val;
    @(negedge clk);
    ld_valid = 0;
    if (to_s) ms[idx] = val; else mr[idx] = val;
  endtask

  task automatic model(input bit sm, input int f, input int x, input int y,
                       input bit p, input bit s);
    logic [W-1:0] orr [D];
    logic [W-1:0] oss [D];
    bit m;
    orr = mr; oss = ms;
    m = sm && s;
    case (f)
      0: begin if (p) mr[x] = orr[y]; if (m) ms[x] = oss[y]; end
      1: begin if (p) mr[x] = oss[y]; if (m) ms[x] = orr[y]; end
      2: begin if (p) ms[x] = orr[y]; if (m) mr[x] = oss[y]; end
      3: begin if (p) ms[x] = oss[y]; if (m) mr[x] = orr[y]; end
      4: begin if (p) mr[x] = oss[y]; if (sm ? s : p) ms[y] = orr[x]; end
      default: ;
    endcase
  endtask

  task automatic run_op(input bit sm, input int f, input int x, input int y,
                        input bit p, input bit s);
    @(negedge clk);
    op_valid = 1; simd_mode = sm; op_code = 3'(f); dst_idx = IW'(x);
    src_idx = IW'(y); cond_pri = p; cond_sec = s;
    @(negedge clk);
    op_valid = 0;
    model(sm, f, x, y, p, s);
  endtask

  task automatic preload();
    for (int i = 0; i < D; i++) begin
      load(0, i, 40'hA000000000 + 40'(i) * 40'h0000100001);
      load(1, i, 40'h5B00000000 + 40'(i) * 40'h0001000011);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    peek_r_idx = 0; peek_s_idx = 0;
    for (int i = 0; i < D; i++) begin mr[i] = '0; ms[i] = '0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all("R1 after reset");

    preload();
    compare_all("R9 load");

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][13], int'(VEC[v][12:10]), int'(VEC[v][9:6]),
             int'(VEC[v][5:2]), VEC[v][1], VEC[v][0]);
      compare_all($sformatf("table vec %0d", v));
    end

    // R9: unused form codes do nothing
    for (int f = 5; f < 8; f++) begin
      run_op(1, f, 4, 5, 1, 1);
      compare_all($sformatf("R9 form %0d", f));
    end

    // R9: strobe low with live fields
    @(negedge clk);
    simd_mode = 1; op_code = 3'd1; dst_idx = 4'd7; src_idx = 4'd8;
    cond_pri = 1; cond_sec = 1;
    @(negedge clk);
    idle_inputs();
    compare_all("R9 strobe low");

    // R9: load colliding with a command is dropped
    @(negedge clk);
    op_valid = 1; simd_mode = 0; op_code = 3'd0; dst_idx = 4'd9; src_idx = 4'd9;
    cond_pri = 1; ld_valid = 1; ld_to_s = 1; ld_idx = 4'd9; ld_data = 40'hDEADBEEF01;
    @(negedge clk);
    idle_inputs();
    compare_all("R9 load vs op");

    // R10: old value before the edge, new value after it
    @(negedge clk);
    op_valid = 1; simd_mode = 0; op_code = 3'd1; dst_idx = 4'd0; src_idx = 4'd14;
    cond_pri = 1; cond_sec = 0;
    peek_r_idx = 4'd0;
    #1;
    chk("R10 before edge", peek_r_data, mr[0]);
    @(negedge clk);
    op_valid = 0;
    model(0, 1, 0, 14, 1, 0);
    peek_r_idx = 4'd0;
    #0.5;
    chk("R10 after edge", peek_r_data, ms[14]);

    // R1: reset mid-run clears the files
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < D; i++) begin mr[i] = '0; ms[i] = '0; end
    @(negedge clk);
    compare_all("R1 second reset");
    rst_n = 1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule